// File: doc/BRIEF.md
# Instruction Cache Control Register Set

This block is the software-visible register set of an instruction cache. A CPU writes and reads four 16-bit registers through a simple synchronous port. The command register takes exactly two legal values. One starts a cache initialization. The other invalidates one line. A 24-bit byte address, split over two registers, names that line. The block also keeps a 16-bit count of tag miscompares, which the cache core reports as single-cycle miss events.

The cache core sees the results as outputs. It gets a one-cycle initialization pulse, a one-cycle flush pulse, and the assembled flush address. Commands are accepted only while the cache is disabled. A command that arrives while the cache is enabled has no effect. The miss counter stops at its maximum value. Software may read the counter at any time and may load it with a new value.

Top module: `cache_cfg_regs`

## Requirements
- R1: After the asynchronous reset is released, every register reads 0, `init_pulse_o` and `flush_pulse_o` are 0, and `flush_addr_o` is 0.
- R2: A write of 0xCE3C to the command register (select 0) while `cache_en_i` is 0 stores that value. `init_pulse_o` is then high for exactly the one cycle after the write edge.
- R3: A write of 0xDE3C to the command register while `cache_en_i` is 0 stores that value. `flush_pulse_o` is then high for exactly the one cycle after the write edge. `flush_addr_o` equals {high register bits 7:0, low register bits 15:0}.
- R4: A command-register write of any value other than 0xCE3C or 0xDE3C leaves the stored command unchanged and raises no pulse.
- R5: A command-register write while `cache_en_i` is 1 leaves the stored command unchanged and raises no pulse.
- R6: Select 1 writes the low flush address register (address bits 15:0). Select 2 writes address bits 23:16 from write data bits 7:0. Bits 15:8 of select 2 always read 0. Both registers are writable regardless of `cache_en_i`.
- R7: Each cycle with `miss_i` high raises the miss count by 1. At 0xFFFF the count holds and does not wrap.
- R8: A write to the miss counter (select 3) loads the write data, and it takes priority over a miss event in the same cycle.
- R9: `rdata_o` combinationally shows the register named by `sel_i`: 0 is the command, 1 is the low address, 2 is the high address, and 3 is the miss count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cache_en_i | input | 1 | Cache enabled; command writes are blocked while high |
| we_i | input | 1 | Register write strobe |
| sel_i | input | 2 | Register select |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the selected register |
| miss_i | input | 1 | One tag miscompare this cycle |
| init_pulse_o | output | 1 | One-cycle initialization request |
| flush_pulse_o | output | 1 | One-cycle single-line flush request |
| flush_addr_o | output | 24 | Byte address of the line to flush |

## Verification
The command register is driven with both legal codes, with neighbouring illegal codes, and with legal codes while the cache is enabled. This separates a decoder that compares the full word from one that compares only part of it or ignores the enable. The address registers are written with patterns that have the upper high byte set. This shows whether the reserved bits leak into readback or into the flush address. The miss counter is run across its saturation point and is written during a miss. These cases separate saturation from wrap-around and show which source wins in a collision.

// File: rtl/cache_cfg_pkg.sv
package cache_cfg_pkg;
  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_FLO  = 2'd1,
    SEL_FHI  = 2'd2,
    SEL_MISS = 2'd3
  } reg_sel_e;

  localparam logic [15:0] CMD_INIT  = 16'hCE3C;
  localparam logic [15:0] CMD_FLUSH = 16'hDE3C;
endpackage

// File: rtl/cache_cmd_decode.sv
module cache_cmd_decode
  import cache_cfg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cache_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cmd_o,
  output logic              init_o,
  output logic              flush_o
);
  logic is_init, is_flush, accept;

  assign is_init  = (wdata_i == DATA_W'(CMD_INIT));
  assign is_flush = (wdata_i == DATA_W'(CMD_FLUSH));
  assign accept   = wr_i && !cache_en_i && (is_init || is_flush);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o   <= '0;
      init_o  <= 1'b0;
      flush_o <= 1'b0;
    end else begin
      init_o  <= accept && is_init;
      flush_o <= accept && is_flush;
      if (accept) cmd_o <= wdata_i;
    end
  end

  AST_FLUSH_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(wr_i && !cache_en_i && wdata_i == DATA_W'(CMD_FLUSH))) // R3
    else $error("flush pulse without legal flush write");
  AST_ILLEGAL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !is_init && !is_flush) |=> ($stable(cmd_o) && !init_o && !flush_o)) // R4
    else $error("illegal command changed state");
  AST_LOCKED_WHEN_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && cache_en_i) |=> ($stable(cmd_o) && !init_o && !flush_o)) // R5
    else $error("command accepted while enabled");
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(init_o && flush_o)) // R2
    else $error("both pulses high");
endmodule

// File: rtl/cache_flush_addr.sv
module cache_flush_addr #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [HI_W-1:0]   hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o <= '0;
      hi_o <= '0;
    end else begin
      if (wr_lo_i) lo_o <= wdata_i;
      if (wr_hi_i) hi_o <= wdata_i[HI_W-1:0];
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_lo_i && !wr_hi_i) |=> ($stable(lo_o) && $stable(hi_o))) // R6
    else $error("flush address moved without write");
endmodule

// File: rtl/cache_miss_counter.sv
module cache_miss_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miss_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_o <= '0;
    else if (wr_i)                       cnt_o <= wdata_i;
    else if (miss_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX)) // R7
    else $error("miss counter wrapped");
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && miss_i && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + 1'b1)) // R7
    else $error("miss not counted");
  AST_SW_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_o == $past(wdata_i))) // R8
    else $error("software load lost");
endmodule

// File: rtl/cache_cfg_regs.sv
module cache_cfg_regs
  import cache_cfg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cache_en_i,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              miss_i,
  output logic              init_pulse_o,
  output logic              flush_pulse_o,
  output logic [ADDR_W-1:0] flush_addr_o
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] cmd_q, lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [CNT_W-1:0]  cnt_q;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(sel_i);

  cache_cmd_decode #(.DATA_W(DATA_W)) u_cmd (
    .clk_i, .rst_ni, .cache_en_i,
    .wr_i    (we_i && sel == SEL_CMD),
    .wdata_i,
    .cmd_o   (cmd_q),
    .init_o  (init_pulse_o),
    .flush_o (flush_pulse_o)
  );

  cache_flush_addr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_faddr (
    .clk_i, .rst_ni,
    .wr_lo_i (we_i && sel == SEL_FLO),
    .wr_hi_i (we_i && sel == SEL_FHI),
    .wdata_i,
    .lo_o    (lo_q),
    .hi_o    (hi_q)
  );

  cache_miss_counter #(.CNT_W(CNT_W)) u_miss (
    .clk_i, .rst_ni, .miss_i,
    .wr_i    (we_i && sel == SEL_MISS),
    .wdata_i (wdata_i[CNT_W-1:0]),
    .cnt_o   (cnt_q)
  );

  assign flush_addr_o = {hi_q, lo_q};

  always_comb begin
    unique case (sel)
      SEL_CMD:  rdata_o = cmd_q;
      SEL_FLO:  rdata_o = lo_q;
      SEL_FHI:  rdata_o = {{(DATA_W-HI_W){1'b0}}, hi_q};
      default:  rdata_o = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
    endcase
  end

  AST_RESV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_FHI) |-> (rdata_o[DATA_W-1:HI_W] == '0)) // R6
    else $error("reserved high bits nonzero");
  AST_FLUSH_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_pulse_o |-> (flush_addr_o[DATA_W-1:0] == lo_q)) // R3
    else $error("flush address mismatch");
endmodule

// File: tb/cache_cfg_regs_bench.sv
module cache_cfg_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_en = 1'b0, we = 1'b0, miss = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        init_p, flush_p;
  logic [23:0] faddr;

  int tests = 0, fails = 0;
  bit done = 0;

  int m_cmd = 0, m_lo = 0, m_hi = 0, m_cnt = 0;
  bit m_init = 0, m_flush = 0;

  always #5 clk = ~clk;

  cache_cfg_regs u_cache_cfg_regs (
    .clk_i(clk), .rst_ni(rst_n), .cache_en_i(cache_en), .we_i(we),
    .sel_i(sel), .wdata_i(wdata), .rdata_o(rdata), .miss_i(miss),
    .init_pulse_o(init_p), .flush_pulse_o(flush_p), .flush_addr_o(faddr)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = 0; m_lo = 0; m_hi = 0; m_cnt = 0; m_init = 0; m_flush = 0;
    end else begin
      m_init = 0; m_flush = 0;
      if (we && sel == 0 && !cache_en && (wdata == 16'hCE3C || wdata == 16'hDE3C)) begin
        m_cmd = wdata;
        m_init = (wdata == 16'hCE3C);
        m_flush = (wdata == 16'hDE3C);
      end
      if (we && sel == 1) m_lo = wdata;
      if (we && sel == 2) m_hi = wdata & 16'h00FF;
      if (we && sel == 3) m_cnt = wdata;
      else if (miss && m_cnt < 65535) m_cnt = m_cnt + 1;
    end
  end

  function automatic int exp_rd(input int s);
    case (s)
      0: return m_cmd;
      1: return m_lo;
      2: return m_hi;
      default: return m_cnt;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) if (rst_n && !done) begin
    chk("R9 rdata", int'(rdata), exp_rd(int'(sel)));
    chk("R2 init_pulse", int'(init_p), int'(m_init));
    chk("R3 flush_pulse", int'(flush_p), int'(m_flush));
    chk("R3/R6 flush_addr", int'(faddr), (m_hi << 16) | m_lo);
  end

  task automatic cyc(input bit w, input int s, input int d, input bit ms, input bit en);
    we = w; sel = 2'(s); wdata = 16'(d); miss = ms; cache_en = en;
    @(negedge clk);
  endtask

  task automatic rd(input string req, input int s, input int exp);
    cyc(0, s, 0, 0, cache_en);
    chk(req, int'(rdata), exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 init", int'(init_p), 0);
    chk("R1 flush", int'(flush_p), 0);
    chk("R1 faddr", int'(faddr), 0);
    for (int s = 0; s < 4; s++) rd("R1 reg", s, 0);

    // R6 address registers, reserved high bits
    cyc(1, 1, 16'hA5C3, 0, 0);
    cyc(1, 2, 16'hFF7E, 0, 1);
    rd("R6 low", 1, 16'hA5C3);
    rd("R6 high reserved", 2, 16'h007E);
    chk("R6 faddr", int'(faddr), 24'h7EA5C3);

    // R2 init command
    cyc(1, 0, 16'hCE3C, 0, 0);
    chk("R2 pulse", int'(init_p), 1);
    cyc(0, 0, 0, 0, 0);
    chk("R2 one cycle", int'(init_p), 0);
    rd("R2 stored", 0, 16'hCE3C);

    // R3 flush command
    cyc(1, 0, 16'hDE3C, 0, 0);
    chk("R3 pulse", int'(flush_p), 1);
    chk("R3 addr", int'(faddr), 24'h7EA5C3);
    cyc(0, 0, 0, 0, 0);
    chk("R3 one cycle", int'(flush_p), 0);
    rd("R3 stored", 0, 16'hDE3C);

    // R4 illegal values
    cyc(1, 0, 16'hCE3D, 0, 0);
    chk("R4 no flush", int'(flush_p), 0);
    chk("R4 no init", int'(init_p), 0);
    cyc(1, 0, 16'hDE3D, 0, 0);
    cyc(1, 0, 16'h0000, 0, 0);
    rd("R4 unchanged", 0, 16'hDE3C);

    // R5 locked while enabled
    cyc(1, 0, 16'hCE3C, 0, 1);
    chk("R5 no init", int'(init_p), 0);
    rd("R5 unchanged", 0, 16'hDE3C);

    // R7 counting
    cyc(0, 3, 0, 1, 1);
    cyc(0, 3, 0, 1, 1);
    cyc(0, 3, 0, 0, 1);
    rd("R7 count", 3, 2);
    cyc(1, 3, 16'hFFFD, 0, 1);
    for (int i = 0; i < 5; i++) cyc(0, 3, 0, 1, 1);
    rd("R7 saturate", 3, 16'hFFFF);

    // R8 write beats miss
    cyc(1, 3, 16'h1234, 1, 1);
    rd("R8 priority", 3, 16'h1234);
    cyc(0, 3, 0, 1, 0);
    rd("R7 after load", 3, 16'h1235);

    // flush after enable removed, new address
    cyc(1, 1, 16'h0001, 0, 0);
    cyc(1, 2, 16'h0080, 0, 0);
    cyc(1, 0, 16'hDE3C, 0, 0);
    chk("R3 addr2", int'(faddr), 24'h800001);
    cyc(0, 0, 0, 0, 0);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end
endmodule